// File: doc/BRIEF.md
# On-Off-Keyed Packet Burst Transmitter

This block turns a short packet held in a local byte buffer into the keying waveform for a low-cost on-off-keyed radio transmitter module. Software, or a neighbouring block, fills the buffer through a byte-wide write port. It then pulses a start strobe together with a repeat count. The transmitter drives one data line and sends the whole frame the requested number of times. A busy flag is high for the whole burst, and a one-cycle done pulse marks its end.

Each frame has four parts. First comes a square-wave training burst that lets the receiver's gain control settle. Then comes a sync marker: one long high and one equally long low. Then the packet bits follow. Each bit is a high and a low of equal length, and the length of that pair tells a one from a zero. Last, the line stays low for a pause before the next frame. All durations are counted in ticks of a microsecond strobe input, so the system clock rate does not affect the air timing. The top two bits of the first packet byte choose how many bytes are sent. Checksums are formed outside the block, before the buffer is loaded.

Top module: `ook_burst_tx`

## Requirements
- R1: After reset, and whenever no burst is in progress, the data line, busy and done are all low.
- R2: Bits [7:6] of buffer byte 0, read when start is accepted, set the frame length: 2'b00 = 4 bytes, 2'b01 = 8, 2'b10 = 16, 2'b11 = 32.
- R3: Every frame opens with TRAIN_CYCLES training cycles. Each cycle is TRAIN_HALF_TICKS ticks high followed by TRAIN_HALF_TICKS ticks low.
- R4: The training burst is followed by a sync marker of SYNC_TICKS ticks high and then SYNC_TICKS ticks low.
- R5: Bytes go out in buffer address order starting at address 0, each most significant bit first. A 0 bit is ZERO_TICKS high then ZERO_TICKS low. A 1 bit is ONE_TICKS high then ONE_TICKS low.
- R6: After the low half of the last bit, the line stays low for a further PAUSE_TICKS ticks that end the frame.
- R7: The frame is sent rep_cnt_i times in a row, with rep_cnt_i sampled at start. A value of 0 selects DEFAULT_REPEATS.
- R8: busy_o rises in the cycle after start is accepted. After the final pause, busy_o falls and done_o is high for exactly that one cycle.
- R9: A start strobe while busy is ignored. It changes neither the frame, the repeat count nor the waveform.
- R10: Buffer writes while busy are ignored. A later burst that is started without reloading sends the original bytes.
- R11: Durations count only cycles with tick_i high. The line holds its level in cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timing strobe, one per microsecond |
| wr_en_i | input | 1 | Buffer write enable |
| wr_addr_i | input | 5 | Buffer byte address |
| wr_data_i | input | 8 | Buffer write data |
| start_i | input | 1 | Starts a burst when idle |
| rep_cnt_i | input | REP_W | Number of frames in the burst (0 selects the default) |
| line_o | output | 1 | Keying output to the transmitter |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The bench rebuilds every frame from its high and low run lengths, measured in ticks, and compares each run with a waveform it computes itself. It covers all four length codes. A design that decoded the length field wrongly would send the wrong number of runs. One that sent least significant bit first, or swapped the one and zero widths, would fail the data runs. One that ended the pause early or late would corrupt the long low run that joins the last bit to the pause. The bench also covers a repeat count of zero, a start and a buffer write in the middle of a burst, and a tick that arrives only every third cycle. A design that reloaded on a late start, let a late write reach the packet, or counted clocks instead of ticks would show a shifted or lengthened waveform, or the wrong number of frames.

// File: rtl/ook_tx_pkg.sv
package ook_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TRAIN,
    PH_SYNC,
    PH_DATA,
    PH_PAUSE
  } phase_e;

  // Length code from the top bits of byte 0: 4 << code bytes.
  function automatic int unsigned frame_bytes(input logic [1:0] code);
    return 32'd4 << code;
  endfunction

  // Half-period of one data bit in ticks.
  function automatic int unsigned bit_ticks(input logic b,
                                            input int unsigned zero_t,
                                            input int unsigned one_t);
    return b ? one_t : zero_t;
  endfunction

endpackage

// File: rtl/ook_frame_buf.sv
module ook_frame_buf #(
  parameter int unsigned BYTES = 32,
  localparam int unsigned AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [1:0]    len_code_o
);

  logic [7:0] mem [BYTES];
  logic       wr_fire;

  assign wr_fire = wr_en_i && !lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(BYTES); i++) mem[i] <= 8'h00;
    end else if (wr_fire) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o  = mem[rd_addr_i];
  assign len_code_o = mem[0][7:6];

  // R10: a write during a burst leaves the addressed byte untouched
  p_locked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && wr_en_i) |=> (mem[$past(wr_addr_i)] == $past(mem[wr_addr_i])));

endmodule

// File: rtl/ook_seg_timer.sv
module ook_seg_timer #(
  parameter int unsigned DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             seg_end_o
);

  logic [DUR_W-1:0] cnt;

  assign seg_end_o = run_i && tick_i && (cnt == dur_i - DUR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt <= '0;
    else if (restart_i || seg_end_o || !run_i)   cnt <= '0;
    else if (tick_i)                             cnt <= cnt + DUR_W'(1);
  end

  // R11: the count never passes the length of the running segment
  p_cnt_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt < dur_i));

  // R11: without a tick the segment cannot end
  p_no_end_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |-> !seg_end_o);

endmodule

// File: rtl/ook_frame_seq.sv
module ook_frame_seq
  import ook_tx_pkg::*;
#(
  parameter int unsigned TRAIN_CYCLES     = 20,
  parameter int unsigned TRAIN_HALF_TICKS = 200,
  parameter int unsigned SYNC_TICKS       = 2000,
  parameter int unsigned ZERO_TICKS       = 300,
  parameter int unsigned ONE_TICKS        = 500,
  parameter int unsigned PAUSE_TICKS      = 5000,
  parameter int unsigned DEFAULT_REPEATS  = 3,
  parameter int unsigned REP_W            = 4,
  parameter int unsigned DUR_W            = 16,
  parameter int unsigned AW               = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [REP_W-1:0] rep_cnt_i,
  input  logic [1:0]       len_code_i,
  input  logic [7:0]       cur_byte_i,
  input  logic             seg_end_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic [DUR_W-1:0] dur_o,
  output logic             run_o,
  output logic             restart_o,
  output logic             line_o,
  output logic             done_o
);

  localparam int unsigned TW = $clog2(TRAIN_CYCLES + 1);
  localparam logic [TW-1:0] TRAIN_LAST = TW'(TRAIN_CYCLES - 1);

  phase_e           phase;
  logic             low_half;
  logic [TW-1:0]    train_idx;
  logic [AW-1:0]    byte_idx;
  logic [2:0]       bit_idx;
  logic [REP_W-1:0] reps_left;
  logic [1:0]       len_code;

  logic             start_ok;
  logic             cur_bit;
  logic [AW-1:0]    last_byte;

  assign start_ok  = start_i && (phase == PH_IDLE);
  assign cur_bit   = cur_byte_i[3'd7 - bit_idx];
  assign last_byte = AW'(frame_bytes(len_code) - 1);
  assign rd_addr_o = byte_idx;
  assign run_o     = (phase != PH_IDLE);
  assign restart_o = start_ok;
  assign line_o    = (phase == PH_TRAIN || phase == PH_SYNC || phase == PH_DATA) && !low_half;

  always_comb begin
    case (phase)
      PH_TRAIN: dur_o = DUR_W'(TRAIN_HALF_TICKS);
      PH_SYNC:  dur_o = DUR_W'(SYNC_TICKS);
      PH_DATA:  dur_o = DUR_W'(bit_ticks(cur_bit, ZERO_TICKS, ONE_TICKS));
      PH_PAUSE: dur_o = DUR_W'(PAUSE_TICKS);
      default:  dur_o = DUR_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      low_half  <= 1'b0;
      train_idx <= '0;
      byte_idx  <= '0;
      bit_idx   <= '0;
      reps_left <= '0;
      len_code  <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_ok) begin
        phase     <= PH_TRAIN;
        low_half  <= 1'b0;
        train_idx <= '0;
        byte_idx  <= '0;
        bit_idx   <= '0;
        len_code  <= len_code_i;
        reps_left <= (rep_cnt_i == '0) ? REP_W'(DEFAULT_REPEATS) : rep_cnt_i;
      end else if (seg_end_i) begin
        low_half <= ~low_half;
        case (phase)
          PH_TRAIN: if (low_half) begin
            if (train_idx == TRAIN_LAST) begin
              train_idx <= '0;
              phase     <= PH_SYNC;
            end else begin
              train_idx <= train_idx + TW'(1);
            end
          end
          PH_SYNC: if (low_half) phase <= PH_DATA;
          PH_DATA: if (low_half) begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
              if (byte_idx == last_byte) begin
                byte_idx <= '0;
                phase    <= PH_PAUSE;
              end else begin
                byte_idx <= byte_idx + AW'(1);
              end
            end
          end
          PH_PAUSE: begin
            low_half <= 1'b0;
            if (reps_left == REP_W'(1)) begin
              phase  <= PH_IDLE;
              done_o <= 1'b1;
            end else begin
              reps_left <= reps_left - REP_W'(1);
              phase     <= PH_TRAIN;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: a start while busy leaves the burst settings alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && start_i && !seg_end_i) |=>
      (reps_left == $past(reps_left) && len_code == $past(len_code)));

  // R8: done lasts exactly one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: done only when the final pause has just ended
  p_done_after_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (phase == PH_IDLE && $past(phase) == PH_PAUSE));

  // R2: the byte pointer stays inside the selected frame length
  p_frame_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (byte_idx <= last_byte));

endmodule

// File: rtl/ook_burst_tx.sv
module ook_burst_tx
  import ook_tx_pkg::*;
#(
  parameter int unsigned TRAIN_CYCLES     = 20,
  parameter int unsigned TRAIN_HALF_TICKS = 200,
  parameter int unsigned SYNC_TICKS       = 2000,
  parameter int unsigned ZERO_TICKS       = 300,
  parameter int unsigned ONE_TICKS        = 500,
  parameter int unsigned PAUSE_TICKS      = 5000,
  parameter int unsigned DEFAULT_REPEATS  = 3,
  parameter int unsigned REP_W            = 4,
  parameter int unsigned DUR_W            = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [4:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             start_i,
  input  logic [REP_W-1:0] rep_cnt_i,
  output logic             line_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int unsigned BUF_BYTES = frame_bytes(2'b11);
  localparam int unsigned AW        = $clog2(BUF_BYTES);

  logic [AW-1:0]    rd_addr;
  logic [7:0]       cur_byte;
  logic [1:0]       len_code;
  logic [DUR_W-1:0] seg_dur;
  logic             seg_run;
  logic             seg_restart;
  logic             seg_end;

  ook_frame_buf #(.BYTES(BUF_BYTES)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_i     (seg_run),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (cur_byte),
    .len_code_o (len_code)
  );

  ook_seg_timer #(.DUR_W(DUR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (seg_run),
    .restart_i (seg_restart),
    .tick_i    (tick_i),
    .dur_i     (seg_dur),
    .seg_end_o (seg_end)
  );

  ook_frame_seq #(
    .TRAIN_CYCLES     (TRAIN_CYCLES),
    .TRAIN_HALF_TICKS (TRAIN_HALF_TICKS),
    .SYNC_TICKS       (SYNC_TICKS),
    .ZERO_TICKS       (ZERO_TICKS),
    .ONE_TICKS        (ONE_TICKS),
    .PAUSE_TICKS      (PAUSE_TICKS),
    .DEFAULT_REPEATS  (DEFAULT_REPEATS),
    .REP_W            (REP_W),
    .DUR_W            (DUR_W),
    .AW               (AW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rep_cnt_i  (rep_cnt_i),
    .len_code_i (len_code),
    .cur_byte_i (cur_byte),
    .seg_end_i  (seg_end),
    .rd_addr_o  (rd_addr),
    .dur_o      (seg_dur),
    .run_o      (seg_run),
    .restart_o  (seg_restart),
    .line_o     (line_o),
    .done_o     (done_o)
  );

  assign busy_o = seg_run;

  // R11: during a burst the line only moves after a tick
  p_line_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (line_o != $past(line_o))) |-> $past(tick_i));

  // R8: done coincides with the fall of busy
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/ook_burst_tx_test.sv
module ook_burst_tx_test;

  localparam int TC = 4, TH = 2, SY = 8, ZR = 3, ON = 5, PS = 10, DR = 3;
  localparam int MAXR = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [4:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       start_i = 1'b0;
  logic [3:0] rep_cnt_i = '0;
  logic       line_o, busy_o, done_o;

  always #2 clk = ~clk;

  ook_burst_tx #(
    .TRAIN_CYCLES(TC), .TRAIN_HALF_TICKS(TH), .SYNC_TICKS(SY),
    .ZERO_TICKS(ZR), .ONE_TICKS(ON), .PAUSE_TICKS(PS),
    .DEFAULT_REPEATS(DR), .REP_W(4), .DUR_W(16)
  ) uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  int tick_div = 1, tick_ph = 0;
  bit mon_en = 0, finished = 0;
  int done_cnt = 0;
  logic [7:0] pkt [32];

  int obs_lvl [MAXR], obs_len [MAXR], obs_n;
  int exp_lvl [MAXR], exp_len [MAXR], exp_tag [MAXR], exp_n;

  // stimulus: {first byte, data seed, repeat count}
  localparam logic [23:0] VEC [6] = '{
    {8'h05, 8'h11, 8'd1}, {8'h4A, 8'h23, 8'd2}, {8'h83, 8'h5C, 8'd1},
    {8'hC1, 8'h9D, 8'd2}, {8'h3F, 8'hA7, 8'd0}, {8'h40, 8'h00, 8'd3}};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  // tick generation and run-length monitor, in ticks
  always @(negedge clk) begin
    bit nt;
    nt = (tick_ph == 0);
    tick_i <= nt;
    tick_ph <= (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    if (mon_en) begin
      if (done_o) done_cnt++;
      if (busy_o && nt) begin
        if (obs_n > 0 && obs_lvl[obs_n-1] == int'(line_o)) obs_len[obs_n-1]++;
        else if (obs_n < MAXR) begin
          obs_lvl[obs_n] = int'(line_o); obs_len[obs_n] = 1; obs_n++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic push(input int lvl, input int len, input int tag);
    if (exp_n > 0 && exp_lvl[exp_n-1] == lvl) begin
      exp_len[exp_n-1] += len; exp_tag[exp_n-1] = tag;
    end else begin
      exp_lvl[exp_n] = lvl; exp_len[exp_n] = len; exp_tag[exp_n] = tag; exp_n++;
    end
  endtask

  // expected waveform from the requirements
  task automatic build_exp(input int reps);
    int nb;
    nb = 4 << pkt[0][7:6];             // R2 length code
    exp_n = 0;
    for (int r = 0; r < reps; r++) begin
      for (int c = 0; c < TC; c++) begin push(1, TH, 3); push(0, TH, 3); end
      push(1, SY, 4); push(0, SY, 4);
      for (int b = 0; b < nb; b++)
        for (int k = 7; k >= 0; k--) begin
          int w;
          w = pkt[b][k] ? ON : ZR;
          push(1, w, 5); push(0, w, 5);
        end
      push(0, PS, 6);
    end
  endtask

  task automatic fill(input logic [7:0] first, input logic [7:0] seed);
    for (int i = 0; i < 32; i++)
      pkt[i] = (i == 0) ? first : 8'((int'(seed) * i * 7 + i * 13 + 90) ^ int'(seed));
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); wr_en_i = 1; wr_addr_i = 5'(i); wr_data_i = pkt[i];
    end
    @(negedge clk); wr_en_i = 0;
  endtask

  // mode: 0 plain, 1 start mid-burst, 2 write mid-burst
  task automatic run(input int reps_in, input int mode, input string tag);
    int reps, sync_seen;
    bit e3, e4, e5, e6;
    reps = (reps_in == 0) ? DR : reps_in;
    build_exp(reps);
    obs_n = 0; done_cnt = 0; mon_en = 1;
    @(negedge clk); start_i = 1; rep_cnt_i = 4'(reps_in);
    @(negedge clk); start_i = 0;
    chk(busy_o == 1'b1, "R8", {tag, " busy after start"}, int'(busy_o), 1);
    if (mode == 1) begin
      repeat (30) @(negedge clk);
      start_i = 1; rep_cnt_i = 4'd1;
      @(negedge clk); start_i = 0;
    end else if (mode == 2) begin
      repeat (30) @(negedge clk);
      wr_en_i = 1; wr_addr_i = 5'd1; wr_data_i = ~pkt[1];
      @(negedge clk); wr_addr_i = 5'd0; wr_data_i = ~pkt[0];
      @(negedge clk); wr_en_i = 0;
    end
    while (busy_o && !finished) @(negedge clk);
    chk(done_o == 1'b1, "R8", {tag, " done in first idle cycle"}, int'(done_o), 1);
    @(negedge clk);
    mon_en = 0;
    chk(done_cnt == 1, "R8", {tag, " done pulse count"}, done_cnt, 1);
    chk(obs_n == exp_n, "R2", {tag, " run count"}, obs_n, exp_n);
    e3 = 0; e4 = 0; e5 = 0; e6 = 0; sync_seen = 0;
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      bit bad;
      bad = (obs_lvl[i] != exp_lvl[i]) || (obs_len[i] != exp_len[i]);
      if (bad && !(e3 | e4 | e5 | e6))
        $display("  %s first mismatch at run %0d: lvl %0d len %0d, want lvl %0d len %0d",
                 tag, i, obs_lvl[i], obs_len[i], exp_lvl[i], exp_len[i]);
      case (exp_tag[i])
        3: e3 |= bad; 4: e4 |= bad; 5: e5 |= bad; default: e6 |= bad;
      endcase
    end
    for (int i = 0; i < obs_n; i++)
      if (obs_lvl[i] == 1 && obs_len[i] == SY) sync_seen++;
    chk(!e3, "R3", {tag, " training runs"}, int'(e3), 0);
    chk(!e4, "R4", {tag, " sync runs"}, int'(e4), 0);
    chk(!e5, "R5", {tag, " data runs"}, int'(e5), 0);
    chk(!e6, "R6", {tag, " pause run"}, int'(e6), 0);
    chk(sync_seen == reps, "R7", {tag, " frames sent"}, sync_seen, reps);
    chk(line_o == 1'b0 && busy_o == 1'b0, "R1", {tag, " idle after burst"},
        int'({line_o, busy_o}), 0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({line_o, busy_o, done_o} == 3'b000, "R1", "outputs in reset",
        int'({line_o, busy_o, done_o}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({line_o, busy_o, done_o} == 3'b000, "R1", "outputs idle after reset",
        int'({line_o, busy_o, done_o}), 0);

    // table of vectors: R2 length codes, R5 data, R7 repeat counts
    for (int v = 0; v < 6; v++) begin
      fill(VEC[v][23:16], VEC[v][15:8]);
      run(int'(VEC[v][7:0]), 0, $sformatf("vec%0d", v));
    end

    // R9: start strobe in the middle of a burst
    fill(8'h47, 8'h6B);
    run(2, 1, "R9 late start");

    // R10: writes in the middle of a burst, then resend without reload
    fill(8'h02, 8'hE3);
    run(1, 2, "R10 late write");
    run(1, 0, "R10 resend");

    // R11: tick only every third cycle
    tick_div = 3;
    fill(8'h49, 8'h3C);
    run(1, 0, "R11 slow tick");
    tick_div = 1;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule